// File: doc/BRIEF.md
# Register Modification Recorder

This block keeps a per-instruction log of the changes that auto-increment and auto-decrement addressing make to general registers, so that a fault handler can reverse them after an abort. Each logged change is one byte: a signed step in the upper five bits and the register index in the lower three. Changes go into a hidden staging word that is wiped at the start of every instruction fetch. The log only becomes visible to software when the translation unit aborts an access.

A freeze input, taken from the three abort-reason bits of the translation status register, protects the visible copy. While any of those bits is set, an abort does not overwrite the visible word. The block also drives a hold signal that tells the faulting-address register not to update. An error output flags a zero record, which is never legal, and a third record within one instruction, since the word holds only two.

Top module: `regmod_recorder`

## Requirements
- R1: After reset, both the visible register `mod_reg` and the staging word are zero, and `rec_err` is low.
- R2: A pulse on `insn_start` clears the staging word. An abort taken right after the pulse, with no record in between, makes `mod_reg` equal to 0x0000.
- R3: The first valid record after an instruction start lands in bits 7:0 of the staging word. Bits 15:8 stay zero.
- R4: The second record of an instruction lands in bits 15:8. Bits 7:0 keep the first record.
- R5: Each record byte holds a signed step in bits 7:3 and a register number in bits 2:0. The byte is stored unchanged.
- R6: A record of value 0x00 asserts `rec_err` for exactly one cycle, on the cycle after it is presented, and leaves the staging word unchanged.
- R7: A third or later record within one instruction asserts `rec_err` for one cycle and leaves the staging word unchanged.
- R8: When `abort_commit` is high and `freeze_bits` is zero, `mod_reg` takes the staging word, including any record presented in the same cycle, on the next edge.
- R9: When any bit of `freeze_bits` is set, `mod_reg` holds its value through an abort. `addr_hold` equals 1 in that same cycle.
- R10: `mod_reg` is readable at any time. It changes only through an unfrozen abort or a reset.
- R11: When `insn_start` and a record arrive in the same cycle, the record becomes the first record of the new instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| insn_start | input | 1 | Start of an instruction fetch; clears the staging word |
| rec_valid | input | 1 | Strobe that qualifies `rec_data` |
| rec_data | input | 8 | Change record: step in [7:3], register in [2:0] |
| abort_commit | input | 1 | Abort occurred; copy the staging word unless frozen |
| freeze_bits | input | 3 | Abort-reason bits from the translation status register |
| mod_reg | output | 16 | Software-visible modification register |
| addr_hold | output | 1 | Tells the faulting-address register to hold |
| rec_err | output | 1 | Invalid (zero) record, or a record beyond the second |

## Verification
The hardest state to reach is an abort that lands in the same cycle as a record. Only a merged commit path shows the second byte in that case. The bench drives a record and `abort_commit` together after one earlier record, then checks that both bytes reach `mod_reg`. A frozen abort that follows a real commit is also driven, to show that the earlier contents survive.

// File: rtl/regmod_pkg.sv
// Shared widths and record helpers for the register modification recorder.
package regmod_pkg;
    localparam int REC_W   = 8;
    localparam int SLOTS   = 2;
    localparam int WORD_W  = REC_W * SLOTS;
    localparam int FRZ_W   = 3;
    localparam int CNT_W   = $clog2(SLOTS + 1);

    typedef logic [REC_W-1:0]  rec_t;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/regmod_stage.sv
// Staging word: collects up to SLOTS records per instruction.
// Assumes insn_start is a single-cycle pulse per fetch; records in the
// same cycle as insn_start belong to the new instruction.
module regmod_stage
    import regmod_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  insn_start,
    input  logic  rec_valid,
    input  rec_t  rec_data,
    output word_t stage_q,
    output word_t stage_next,
    output logic  err_q
);
    logic [CNT_W-1:0] cnt_q, cnt_base, cnt_next;
    word_t            base;
    logic             accept, err_next;

    // Combine the instruction clear with the incoming record.
    always_comb begin
        base       = insn_start ? '0 : stage_q;
        cnt_base   = insn_start ? '0 : cnt_q;
        accept     = rec_valid && (rec_data != '0) && (cnt_base < CNT_W'(SLOTS));
        err_next   = rec_valid && !accept;
        stage_next = base;
        cnt_next   = cnt_base;
        if (accept) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (cnt_base == CNT_W'(s))
                    stage_next[s*REC_W +: REC_W] = rec_data;
            end
            cnt_next = cnt_base + 1'b1;
        end
    end

    // Register the staging word, the slot count and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            stage_q <= stage_next;
            cnt_q   <= cnt_next;
            err_q   <= err_next;
        end
    end

    assert_zero_rec_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_data == '0) |=> err_q);
    assert_stage_kept_on_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_data == '0 && !insn_start) |=> $stable(stage_q));
    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(SLOTS));
endmodule

// File: rtl/regmod_commit.sv
// Visible register: loads the staged word on an unfrozen abort.
// Assumes freeze bits are the abort-reason bits of the status register.
module regmod_commit
    import regmod_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort_commit,
    input  logic [FRZ_W-1:0] freeze_bits,
    input  word_t            stage_next,
    output word_t            vis_q,
    output logic             frozen
);
    // Freeze when any reason bit is set.
    always_comb frozen = |freeze_bits;

    // Load the visible copy on an abort unless frozen.
    always_ff @(posedge clk) begin
        if (!rst_n)                       vis_q <= '0;
        else if (abort_commit && !frozen) vis_q <= stage_next;
    end

    assert_frozen_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_bits != '0) |=> $stable(vis_q));
    assert_only_abort_changes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !abort_commit |=> $stable(vis_q));
endmodule

// File: rtl/regmod_recorder.sv
// Top: register modification recorder. Stages per-instruction records and
// exposes them on an abort; holds both visible registers while frozen.
module regmod_recorder
    import regmod_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        insn_start,
    input  logic        rec_valid,
    input  logic [7:0]  rec_data,
    input  logic        abort_commit,
    input  logic [2:0]  freeze_bits,
    output logic [15:0] mod_reg,
    output logic        addr_hold,
    output logic        rec_err
);
    word_t stage_q, stage_next, vis_q;
    logic  frozen;

    regmod_stage u_stage (
        .clk(clk), .rst_n(rst_n), .insn_start(insn_start),
        .rec_valid(rec_valid), .rec_data(rec_data),
        .stage_q(stage_q), .stage_next(stage_next), .err_q(rec_err)
    );

    regmod_commit u_commit (
        .clk(clk), .rst_n(rst_n), .abort_commit(abort_commit),
        .freeze_bits(freeze_bits), .stage_next(stage_next),
        .vis_q(vis_q), .frozen(frozen)
    );

    // Drive the outputs.
    always_comb begin
        mod_reg   = vis_q;
        addr_hold = frozen;
    end

    assert_hold_tracks_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hold == (freeze_bits != 3'b000));
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_start && !rec_valid) |=> stage_q == '0);
    assert_err_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_err && !$past(rec_valid)) |-> 1'b0);
endmodule

// File: tb/regmod_recorder_tb.sv
module regmod_recorder_tb;
    logic clk = 0, rst_n = 0, insn_start = 0, rec_valid = 0, abort_commit = 0;
    logic [7:0]  rec_data = 0;
    logic [2:0]  freeze_bits = 0;
    logic [15:0] mod_reg;
    logic addr_hold, rec_err;
    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    regmod_recorder u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs, then sample after the edge.
    task automatic cyc(input logic st, input logic rv, input logic [7:0] rd,
                       input logic ab, input logic [2:0] fz);
        insn_start = st; rec_valid = rv; rec_data = rd; abort_commit = ab; freeze_bits = fz;
        @(posedge clk); #1;
        insn_start = 0; rec_valid = 0; abort_commit = 0;
    endtask

    task automatic t_reset;
        chk("R1 mod_reg", mod_reg, 0);
        chk("R1 rec_err", rec_err, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R1 staging zero", mod_reg, 0);
    endtask

    task automatic t_one_and_two;
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 8'h13, 0, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R3 first low byte", mod_reg, 16'h0013);
        cyc(0, 1, 8'hF6, 0, 0);  // step -2 on r6: bits 7:3 = 11110
        cyc(0, 0, 0, 1, 0);
        chk("R4 second high byte", mod_reg, 16'hF613);
        chk("R5 byte kept", mod_reg[15:8], 8'hF6);
    endtask

    task automatic t_clear;
        cyc(1, 0, 0, 0, 0);
        chk("R10 stable after start", mod_reg, 16'hF613);
        cyc(0, 0, 0, 1, 0);
        chk("R2 cleared", mod_reg, 0);
    endtask

    task automatic t_errors;
        cyc(1, 1, 8'h00, 0, 0);
        chk("R6 zero flagged", rec_err, 1);
        cyc(0, 0, 0, 0, 0);
        chk("R6 one cycle", rec_err, 0);
        cyc(0, 1, 8'h0A, 0, 0);
        chk("R6 valid no err", rec_err, 0);
        cyc(0, 1, 8'h0B, 0, 0);
        cyc(0, 1, 8'h0C, 0, 0);
        chk("R7 third flagged", rec_err, 1);
        cyc(0, 0, 0, 1, 0);
        chk("R7 stage unchanged", mod_reg, 16'h0B0A);
    endtask

    task automatic t_same_cycle;
        cyc(1, 1, 8'h21, 0, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R11 start+record", mod_reg, 16'h0021);
        cyc(0, 1, 8'h42, 1, 0);
        chk("R8 merged commit", mod_reg, 16'h4221);
    endtask

    task automatic t_freeze;
        cyc(1, 1, 8'h55, 0, 3'b100);
        chk("R9 hold out", addr_hold, 1);
        cyc(0, 0, 0, 1, 3'b010);
        chk("R9 frozen keeps", mod_reg, 16'h4221);
        cyc(0, 0, 0, 1, 3'b001);
        chk("R9 frozen keeps bit0", mod_reg, 16'h4221);
        cyc(0, 0, 0, 0, 0);
        chk("R9 hold released", addr_hold, 0);
        cyc(0, 0, 0, 1, 0);
        chk("R8 unfrozen commit", mod_reg, 16'h0055);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1 rst_n = 1;
        t_reset;
        t_one_and_two;
        t_clear;
        t_errors;
        t_same_cycle;
        t_freeze;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule